// File: doc/BRIEF.md
# Multi-Mode Synchronous Serial Slave Port

This block is the host-facing serial port of a data converter. Each frame moves one 16-bit word in each direction. The host shifts a control word in on the data input, and the port shifts back a result word on a data output that can be switched to high impedance. The host supplies the bit clock and a frame signal. The port samples all three host lines into its own faster system clock through two-stage synchronisers and detects every edge in that domain. Inside the chip, the converter core hands over a 12-bit result through a parallel word and a load strobe. It collects each finished 16-bit control word from a parallel output that carries a one-cycle valid strobe.

A two-bit mode select picks the framing style. In level framing the frame signal is active low and bounds the frame. It can also be held low for good, and the port then cuts the bit stream into 16-bit frames by itself. In edge framing a falling edge of the frame signal starts a frame, and the port counts the 16 bits on its own, so the frame signal may go high again early. A polarity input decides which bit-clock edge captures input data and which edge launches output data.

Top module: `ssp_port`

## Requirements
- R1: After reset, the output enable, the output bit, the valid strobe and the received word are all zero.
- R2: Input bits are taken most significant first. After the 16th capture edge of a frame, the received word holds the 16 captured bits, with the first bit in bit 15.
- R3: The output word is 16 bits, sent bit 15 first. Bits 15 to 12 are zero, so the first bit is a leading zero. Bits 11 to 0 are the 12-bit result held when the frame starts. A new result loaded during a frame shows up only in the next frame.
- R4: With mode select 00 (level framing), the output is enabled from the falling edge of the frame signal and disabled after the frame signal rises. While disabled, the output bit reads 0.
- R5: With polarity 1, data is captured on rising bit-clock edges and launched on falling edges. With polarity 0, the two edges are swapped.
- R6: In level framing with the frame signal held low, each run of 16 capture edges forms a complete frame, and the next frame follows directly.
- R7: With mode select 01 (edge framing), a frame starts on a falling edge of the frame signal and runs for 16 capture edges even if the frame signal goes high again. The output is disabled once the 16th bit is captured.
- R8: In level framing, a frame that the frame signal ends before 16 bits produces no valid strobe, and the next frame is received correctly.
- R9: A new falling edge of the frame signal drops any partial frame and restarts the bit count.
- R10: The valid strobe lasts exactly one system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel_i | input | 2 | Framing select: 00 level, 01 edge; other codes act as level |
| pol_i | input | 1 | Edge polarity: 1 captures on rising edges, 0 captures on falling edges |
| sclk_i | input | 1 | Bit clock from the host |
| sync_n_i | input | 1 | Frame signal from the host |
| din_i | input | 1 | Serial data in |
| tx_data_i | input | 12 | Result word to send |
| tx_load_i | input | 1 | Loads tx_data_i into the hold register |
| dout_o | output | 1 | Serial data out |
| dout_en_o | output | 1 | Output enable for the data-out pad (0 means high impedance) |
| rx_word_o | output | 16 | Last complete received word |
| rx_valid_o | output | 1 | One-cycle strobe when rx_word_o updates |

## Verification
Each host line passes two synchroniser flops and one state register, so a port response comes three system clocks after the host edge that causes it. An output bit changes three clocks after a launch edge. The valid strobe and the new word appear three clocks after the 16th capture edge. The output enable follows the frame signal by three clocks. The bench holds each bit-clock phase for eight system clocks and reads the output bit just before it makes the capture edge, so every launched bit has settled by then. It checks the enable eight clocks after moving the frame signal, and a monitor compares each valid word against a queue of expected words on the falling system-clock edge.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    typedef enum logic [1:0] {
        FRM_LEVEL = 2'b00,
        FRM_EDGE  = 2'b01,
        FRM_RES2  = 2'b10,
        FRM_RES3  = 2'b11
    } frame_mode_e;

endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
    parameter int                WIDTH   = 3,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] ff_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff_q <= {STAGES{RST_VAL[b]}};
            else        ff_q <= {ff_q[STAGES-2:0], d_i[b]};
        end
        assign q_o[b] = ff_q[STAGES-1];
    end

endmodule

// File: rtl/ssp_edge.sv
module ssp_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pol_i,
    input  logic sclk_i,
    input  logic sync_i,
    output logic cap_o,
    output logic launch_o,
    output logic sync_fall_o
);

    logic sclk_q;
    logic sync_q;
    logic rise;
    logic fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            sync_q <= 1'b1;
        end else begin
            sclk_q <= sclk_i;
            sync_q <= sync_i;
        end
    end

    assign rise        = sclk_i & ~sclk_q;
    assign fall        = ~sclk_i & sclk_q;
    assign cap_o       = pol_i ? rise : fall;
    assign launch_o    = pol_i ? fall : rise;
    assign sync_fall_o = sync_q & ~sync_i;

endmodule

// File: rtl/ssp_port.sv
module ssp_port #(
    parameter int WORD_W      = 16,
    parameter int DATA_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel_i,
    input  logic              pol_i,
    input  logic              sclk_i,
    input  logic              sync_n_i,
    input  logic              din_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_load_i,
    output logic              dout_o,
    output logic              dout_en_o,
    output logic [WORD_W-1:0] rx_word_o,
    output logic              rx_valid_o
);
    import ssp_pkg::*;

    localparam int             CNT_W = $clog2(WORD_W);
    localparam int             PAD_W = WORD_W - DATA_W;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  bit_cnt;
        logic [WORD_W-1:0] rx_sh;
        logic [WORD_W-1:0] tx_sh;
        logic              out_bit;
        logic [WORD_W-1:0] rx_word;
        logic              rx_valid;
        logic [DATA_W-1:0] hold;
    } ssp_state_t;

    ssp_state_t st_d, st_q;

    logic [2:0] raw_s;
    logic       sclk_s, sync_s, din_s;
    logic       cap, launch, sync_fall;
    logic       level_mode;

    ssp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({din_i, sync_n_i, sclk_i}),
        .q_o   (raw_s)
    );
    assign {din_s, sync_s, sclk_s} = raw_s;

    ssp_edge u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .pol_i       (pol_i),
        .sclk_i      (sclk_s),
        .sync_i      (sync_s),
        .cap_o       (cap),
        .launch_o    (launch),
        .sync_fall_o (sync_fall)
    );

    assign level_mode = (frame_mode_e'(mode_sel_i) != FRM_EDGE);

    always_comb begin
        st_d          = st_q;
        st_d.rx_valid = 1'b0;
        if (tx_load_i) st_d.hold = tx_data_i;

        if (sync_fall) begin
            st_d.active  = 1'b1;
            st_d.bit_cnt = '0;
            st_d.tx_sh   = {{PAD_W{1'b0}}, st_q.hold};
            st_d.out_bit = 1'b0;
        end else if (level_mode && sync_s) begin
            st_d.active  = 1'b0;
            st_d.bit_cnt = '0;
            st_d.out_bit = 1'b0;
        end else if (st_q.active) begin
            if (launch) begin
                st_d.out_bit = st_q.tx_sh[WORD_W-1];
                st_d.tx_sh   = {st_q.tx_sh[WORD_W-2:0], 1'b0};
            end
            if (cap) begin
                st_d.rx_sh = {st_q.rx_sh[WORD_W-2:0], din_s};
                if (st_q.bit_cnt == LAST) begin
                    st_d.rx_word  = {st_q.rx_sh[WORD_W-2:0], din_s};
                    st_d.rx_valid = 1'b1;
                    st_d.bit_cnt  = '0;
                    st_d.tx_sh    = {{PAD_W{1'b0}}, st_q.hold};
                    if (!level_mode) begin
                        st_d.active  = 1'b0;
                        st_d.out_bit = 1'b0;
                    end
                end else begin
                    st_d.bit_cnt = st_q.bit_cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout_o     = st_q.out_bit;
    assign dout_en_o  = st_q.active;
    assign rx_word_o  = st_q.rx_word;
    assign rx_valid_o = st_q.rx_valid;

endmodule

// File: rtl/ssp_port_chk.sv
module ssp_port_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_sel_i,
    input logic              sync_s,
    input logic              dout_o,
    input logic              dout_en_o,
    input logic [WORD_W-1:0] rx_word_o,
    input logic              rx_valid_o
);

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o); // R10

    AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid_o |-> $stable(rx_word_o)); // R2

    AST_LEVEL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel_i != 2'b01 && sync_s) |=> !dout_en_o); // R4

    AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en_o |-> !dout_o); // R4

    AST_VALID_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> $past(dout_en_o)); // R8

endmodule

bind ssp_port ssp_port_chk #(.WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sel_i (mode_sel_i),
    .sync_s     (sync_s),
    .dout_o     (dout_o),
    .dout_en_o  (dout_en_o),
    .rx_word_o  (rx_word_o),
    .rx_valid_o (rx_valid_o)
);

// File: tb/ssp_port_bench.sv
`timescale 1ns/1ps
module ssp_port_bench;

    localparam int H = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_sel = 2'b00;
    logic        pol = 1'b1;
    logic        sclk = 1'b1;
    logic        sync_n = 1'b1;
    logic        din = 1'b0;
    logic [11:0] tx_data = '0;
    logic        tx_load = 1'b0;
    logic        dout, dout_en, rx_valid;
    logic [15:0] rx_word;

    int n_chk = 0;
    int n_bad = 0;
    int n_valid = 0;
    bit done = 0;
    bit prev_v = 0;
    logic [15:0] exp_q[$];

    always #2 clk = ~clk;

    ssp_port u_ssp_port (
        .clk(clk), .rst_n(rst_n), .mode_sel_i(mode_sel), .pol_i(pol),
        .sclk_i(sclk), .sync_n_i(sync_n), .din_i(din),
        .tx_data_i(tx_data), .tx_load_i(tx_load),
        .dout_o(dout), .dout_en_o(dout_en),
        .rx_word_o(rx_word), .rx_valid_o(rx_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops the scoreboard on each valid strobe
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                n_valid++;
                chk(!prev_v, "R10 strobe width", 32'(prev_v), 32'd0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected valid", 32'(rx_word), 32'hFFFF_FFFF);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    chk(rx_word == e, "R2 received word", 32'(rx_word), 32'(e));
                end
            end
            prev_v = rx_valid;
        end
    end

    task automatic set_pol(input logic p);
        pol = p;
        sclk = p;
        wait_n(H);
    endtask

    task automatic load_tx(input logic [11:0] v);
        tx_data = v;
        tx_load = 1'b1;
        wait_n(1);
        tx_load = 1'b0;
        wait_n(1);
    endtask

    task automatic run_bits(input logic [15:0] w, input int n, input int rel_at,
                            output logic [15:0] got);
        got = '0;
        for (int i = 0; i < n; i++) begin
            sclk = ~sclk;
            din = w[15-i];
            wait_n(H);
            got = {got[14:0], dout};
            sclk = ~sclk;
            wait_n(H);
            if (i == rel_at) sync_n = 1'b1;
        end
    endtask

    task automatic level_frame(input logic [15:0] w, input logic [11:0] tx, input string req);
        logic [15:0] g;
        sync_n = 1'b0;
        wait_n(H);
        chk(dout_en == 1'b1, {req, " R4 enable on"}, 32'(dout_en), 32'd1);
        exp_q.push_back(w);
        run_bits(w, 16, -1, g);
        chk(g == {4'h0, tx}, {req, " R3 sent word"}, 32'(g), 32'({4'h0, tx}));
        sync_n = 1'b1;
        wait_n(H);
        chk(dout_en == 1'b0, {req, " R4 enable off"}, 32'(dout_en), 32'd0);
    endtask

    initial begin
        logic [15:0] g1, g2;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(2);
        chk(dout_en == 1'b0 && dout == 1'b0, "R1 outputs idle", {30'd0, dout_en, dout}, 32'd0);
        chk(rx_valid == 1'b0, "R1 no strobe", 32'(rx_valid), 32'd0);
        chk(rx_word == 16'h0, "R1 word clear", 32'(rx_word), 32'd0);

        // level framing, polarity 1
        load_tx(12'hA5C);
        level_frame(16'hC3A1, 12'hA5C, "R2 R5 pol1");
        level_frame(16'h0001, 12'hA5C, "R2 lsb");

        // result latched at frame start (R3)
        load_tx(12'hABC);
        sync_n = 1'b0;
        wait_n(H);
        exp_q.push_back(16'h8E7F);
        run_bits(16'h8E7F, 8, -1, g1);
        load_tx(12'h123);
        run_bits(16'h7F00, 8, -1, g2);
        chk({g1[7:0], g2[7:0]} == 16'h0ABC, "R3 latched result", 32'({g1[7:0], g2[7:0]}), 32'h0ABC);
        chk(g1[7] == 1'b0, "R3 leading zero", 32'(g1[7]), 32'd0);
        sync_n = 1'b1;
        wait_n(H);
        level_frame(16'h5A5A, 12'h123, "R3 next frame");

        // polarity 0 (R5)
        set_pol(1'b0);
        level_frame(16'h9876, 12'h123, "R5 pol0");
        set_pol(1'b1);

        // frame signal held low (R6)
        load_tx(12'hF0F);
        sync_n = 1'b0;
        wait_n(H);
        exp_q.push_back(16'h1234);
        exp_q.push_back(16'hFEDC);
        run_bits(16'h1234, 16, -1, g1);
        run_bits(16'hFEDC, 16, -1, g2);
        chk(g1 == 16'h0F0F, "R6 first word out", 32'(g1), 32'h0F0F);
        chk(g2 == 16'h0F0F, "R6 second word out", 32'(g2), 32'h0F0F);
        chk(dout_en == 1'b1, "R6 still enabled", 32'(dout_en), 32'd1);
        sync_n = 1'b1;
        wait_n(H);

        // short level frame is dropped (R8)
        begin
            int v0;
            v0 = n_valid;
            sync_n = 1'b0;
            wait_n(H);
            run_bits(16'hFFFF, 7, -1, g1);
            sync_n = 1'b1;
            wait_n(2 * H);
            chk(n_valid == v0, "R8 no strobe on short frame", 32'(n_valid), 32'(v0));
        end
        level_frame(16'h2468, 12'hF0F, "R8 recovery");

        // edge framing with early release (R7)
        mode_sel = 2'b01;
        load_tx(12'h3C5);
        sync_n = 1'b0;
        wait_n(H);
        exp_q.push_back(16'hB7E2);
        run_bits(16'hB7E2, 4, 0, g1);
        chk(dout_en == 1'b1, "R7 enable held after release", 32'(dout_en), 32'd1);
        run_bits(16'h7E20, 12, -1, g2);
        chk({g1[3:0], g2[11:0]} == 16'h03C5, "R7 sent word", 32'({g1[3:0], g2[11:0]}), 32'h03C5);
        wait_n(H);
        chk(dout_en == 1'b0, "R7 enable off at frame end", 32'(dout_en), 32'd0);

        // edge framing restart (R9)
        begin
            int v0;
            v0 = n_valid;
            sync_n = 1'b0;
            wait_n(H);
            run_bits(16'hFFFF, 5, -1, g1);
            sync_n = 1'b1;
            wait_n(H);
            sync_n = 1'b0;
            wait_n(H);
            exp_q.push_back(16'h4D21);
            run_bits(16'h4D21, 16, -1, g2);
            sync_n = 1'b1;
            wait_n(H);
            chk(n_valid == v0 + 1, "R9 one strobe after restart", 32'(n_valid), 32'(v0 + 1));
            chk(g2 == 16'h03C5, "R9 restarted word out", 32'(g2), 32'h03C5);
        end

        wait_n(2 * H);
        chk(exp_q.size() == 0, "R2 all words received", 32'(exp_q.size()), 32'd0);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule